// File: doc/BRIEF.md
# Register Access Channel Controller

This block is one host-side channel for reaching a remote bank of 16-bit registers. Software writes a single 32-bit command word; the channel splits it into a direction flag, a halfword register address and write data, presents the transaction on a request/acknowledge port toward the remote side, and reports its progress through a packed status word that software polls.

Reads are not self-completing. When the remote side returns read data, the channel parks in a dedicated state with the data held in the status word until software writes a 1 to a clear strobe. The same strobe is the recovery path when software finds the channel left in that state. Writes return to idle as soon as the remote side acknowledges. A command written while the channel is busy is dropped and raises a sticky error flag. A separate control write sets an init-done flag that only reset clears.

Top module: `register_access_channel`

## Requirements
- R1: After a synchronous active-low reset the status word reads 32'h0010_0000 (state idle, sync-idle set, everything else zero), `cmd_err` is 0 and `rmt_req` is 0.
- R2: A command word carries the write flag in bit 31 (1 = write, 0 = read), the halfword address in bits 30:16 and the write data in bits 15:0; these appear unchanged on `rmt_we`, `rmt_addr` and `rmt_wdata` while the request is issued and stay stable until it completes.
- R3: An accepted command moves the state field from idle (0) to request (2) on the next edge and to wait-for-data (4) on the edge after; `rmt_req` is high for exactly the one cycle spent in the request state.
- R4: In wait-for-data, an acknowledge on a read captures `rmt_rdata` into status bits 15:0 and moves the state field to wait-for-valid-clear (6).
- R5: In wait-for-valid-clear the state and read data hold until `clr_wr` is pulsed with `clr_bit` = 1, after which the state is idle; a clear with `clr_bit` = 0, or any clear outside that state, changes nothing.
- R6: In wait-for-data, an acknowledge on a write returns the state field to idle without any clear strobe.
- R7: A command written while the state field is not idle produces no remote request, leaves the transaction in progress untouched, and sets `cmd_err`, which stays set until reset.
- R8: Status bit 20 (sync-idle) is 0 from the request state until the remote acknowledge and 1 otherwise; status bit 19 (request pending) is 1 only in the request state.
- R9: Status bit 21 (init-done) is set by pulsing `init_wr` with `init_bit` = 1, is unaffected by `init_bit` = 0, and is cleared only by reset.
- R10: Status bits 31:22 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word: write flag, halfword address, write data |
| clr_wr | input | 1 | Valid-clear strobe write |
| clr_bit | input | 1 | Value written with the valid-clear strobe; 1 releases a parked read |
| init_wr | input | 1 | Init-done control write strobe |
| init_bit | input | 1 | Value written to init-done; 1 sets the flag |
| status_word | output | 32 | Packed status: read data, state, pending, sync-idle, init-done |
| cmd_err | output | 1 | Sticky flag: a command arrived while busy |
| rmt_req | output | 1 | Request to the remote side, one cycle per transaction |
| rmt_we | output | 1 | Direction of the current transaction, 1 = write |
| rmt_addr | output | 15 | Halfword register address of the current transaction |
| rmt_wdata | output | 16 | Write data of the current transaction |
| rmt_ack | input | 1 | Remote acknowledge, one cycle |
| rmt_rdata | input | 16 | Remote read data, valid with the acknowledge |

## Verification
The bound checker watches the state sequencing on every cycle: the single-cycle request, the request-to-wait step, read capture into the parked state, the parked state holding until a clear of 1, writes returning straight to idle, stability of the remote fields while a transaction is open, and the stickiness of both the error and init-done flags. What only the bench's scenarios show is end-to-end data integrity: that a value written to an address comes back on a later read at the boundary addresses, that a command dropped while busy never reaches the remote side, that a clear of 0 or an idle clear leaves the status word intact, and that a mid-run reset returns the exact reset status.

// File: rtl/rac_pkg.sv
// Package: shared state encoding for the register access channel.
// Assumes: state codes are visible to software through the status word,
// so their values are fixed and must not be re-encoded.
package rac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd2,
        ST_WDATA = 3'd4,
        ST_WCLR  = 3'd6
    } chan_state_e;

    localparam int STATE_W = 3;

    // Offsets of the flag fields above the read data field.
    localparam int OFS_STATE   = 0;
    localparam int OFS_PENDING = 3;
    localparam int OFS_SYNC    = 4;
    localparam int OFS_INIT    = 5;
    localparam int FLAG_SPAN   = 6;

endpackage

// File: rtl/rac_cmd_decode.sv
// Module: rac_cmd_decode
// Splits a command word into its write flag, halfword address and data.
// Assumes: the write flag is the top bit, the data occupies the low
// DATA_W bits and the address fills everything in between.
module rac_cmd_decode #(
    parameter int CMD_W  = 32,
    parameter int DATA_W = 16,
    localparam int ADDR_W = CMD_W - 1 - DATA_W
) (
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              is_write,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    // Field extraction, purely combinational.
    always_comb begin
        is_write = cmd_word[CMD_W-1];
        addr     = cmd_word[CMD_W-2:DATA_W];
        wdata    = cmd_word[DATA_W-1:0];
    end

endmodule

// File: rtl/rac_fsm.sv
// Module: rac_fsm
// Transaction sequencer: accepts a command only in idle, issues a one-cycle
// remote request, waits for the acknowledge, then either returns to idle
// (write) or parks the read data until a clear strobe of 1 arrives (read).
// Assumes: the remote side acknowledges once per request, at any time after
// the request cycle; acknowledges outside wait-for-data are ignored.
module rac_fsm
    import rac_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              dec_write,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic [DATA_W-1:0] dec_wdata,
    input  logic              clr_wr,
    input  logic              clr_bit,
    input  logic              rmt_ack,
    input  logic [DATA_W-1:0] rmt_rdata,
    output chan_state_e       state,
    output logic              rmt_req,
    output logic              rmt_we,
    output logic [ADDR_W-1:0] rmt_addr,
    output logic [DATA_W-1:0] rmt_wdata,
    output logic [DATA_W-1:0] rdata_q,
    output logic              cmd_err
);

    chan_state_e       state_q, state_d;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              err_q;
    logic              accept;
    logic              release_rd;

    // Qualify the incoming strobes against the current state.
    always_comb begin
        accept     = cmd_wr && (state_q == ST_IDLE);
        release_rd = clr_wr && clr_bit;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (accept) state_d = ST_REQ;
            ST_REQ:   state_d = ST_WDATA;
            ST_WDATA: if (rmt_ack) state_d = we_q ? ST_IDLE : ST_WCLR;
            ST_WCLR:  if (release_rd) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Command latch: captured only when a command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= dec_write;
            addr_q  <= dec_addr;
            wdata_q <= dec_wdata;
        end
    end

    // Read data capture on a read acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (state_q == ST_WDATA && rmt_ack && !we_q)
            rdata_q <= rmt_rdata;
    end

    // Sticky busy-command error.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (cmd_wr && state_q != ST_IDLE)
            err_q <= 1'b1;
    end

    // Output drive.
    always_comb begin
        state     = state_q;
        rmt_req   = (state_q == ST_REQ);
        rmt_we    = we_q;
        rmt_addr  = addr_q;
        rmt_wdata = wdata_q;
        cmd_err   = err_q;
    end

endmodule

// File: rtl/rac_status.sv
// Module: rac_status
// Holds the init-done flag and packs the software-visible status word.
// Assumes: STS_W leaves room for the read data plus six flag bits; any
// bits above them read zero.
module rac_status
    import rac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int STS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_wr,
    input  logic              init_bit,
    input  chan_state_e       state,
    input  logic [DATA_W-1:0] rdata,
    output logic [STS_W-1:0]  status_word
);

    localparam int FLD = DATA_W;

    logic init_q;
    logic pending;
    logic sync_idle;

    // Init-done flag: set by a control write of 1, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            init_q <= 1'b0;
        else if (init_wr && init_bit)
            init_q <= 1'b1;
    end

    // Derived flags: pending while issuing, not sync-idle while outstanding.
    always_comb begin
        pending   = (state == ST_REQ);
        sync_idle = !((state == ST_REQ) || (state == ST_WDATA));
    end

    // Status packing.
    always_comb begin
        status_word = '0;
        status_word[DATA_W-1:0]                          = rdata;
        status_word[FLD+OFS_STATE +: STATE_W]             = state;
        status_word[FLD+OFS_PENDING]                      = pending;
        status_word[FLD+OFS_SYNC]                         = sync_idle;
        status_word[FLD+OFS_INIT]                         = init_q;
    end

endmodule

// File: rtl/register_access_channel.sv
// Module: register_access_channel
// Top of one host-side register access channel: command decode, the
// transaction sequencer and the status packer.
// Assumes: the remote side answers each request with one acknowledge pulse.
module register_access_channel
    import rac_pkg::*;
#(
    parameter int CMD_W  = 32,
    parameter int DATA_W = 16,
    parameter int STS_W  = 32,
    localparam int ADDR_W = CMD_W - 1 - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              clr_wr,
    input  logic              clr_bit,
    input  logic              init_wr,
    input  logic              init_bit,
    output logic [STS_W-1:0]  status_word,
    output logic              cmd_err,
    output logic              rmt_req,
    output logic              rmt_we,
    output logic [ADDR_W-1:0] rmt_addr,
    output logic [DATA_W-1:0] rmt_wdata,
    input  logic              rmt_ack,
    input  logic [DATA_W-1:0] rmt_rdata
);

    logic              dec_write;
    logic [ADDR_W-1:0] dec_addr;
    logic [DATA_W-1:0] dec_wdata;
    chan_state_e       state;
    logic [DATA_W-1:0] rdata_q;

    rac_cmd_decode #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_dec (
        .cmd_word (cmd_word),
        .is_write (dec_write),
        .addr     (dec_addr),
        .wdata    (dec_wdata)
    );

    rac_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .dec_write (dec_write),
        .dec_addr  (dec_addr),
        .dec_wdata (dec_wdata),
        .clr_wr    (clr_wr),
        .clr_bit   (clr_bit),
        .rmt_ack   (rmt_ack),
        .rmt_rdata (rmt_rdata),
        .state     (state),
        .rmt_req   (rmt_req),
        .rmt_we    (rmt_we),
        .rmt_addr  (rmt_addr),
        .rmt_wdata (rmt_wdata),
        .rdata_q   (rdata_q),
        .cmd_err   (cmd_err)
    );

    rac_status #(.DATA_W(DATA_W), .STS_W(STS_W)) u_sts (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_wr     (init_wr),
        .init_bit    (init_bit),
        .state       (state),
        .rdata       (rdata_q),
        .status_word (status_word)
    );

endmodule

// File: rtl/rac_checker.sv
// Module: rac_checker
// Cycle-by-cycle properties of the register access channel, observed at
// its ports and bound to the top module.
module rac_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 15,
    parameter int STS_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic              clr_wr,
    input logic              clr_bit,
    input logic              rmt_req,
    input logic              rmt_we,
    input logic [ADDR_W-1:0] rmt_addr,
    input logic [DATA_W-1:0] rmt_wdata,
    input logic              rmt_ack,
    input logic [DATA_W-1:0] rmt_rdata,
    input logic [STS_W-1:0]  status_word,
    input logic              cmd_err
);

    logic [2:0]        st;
    logic [DATA_W-1:0] rd;
    logic              sync_f;
    logic              pend_f;
    logic              init_f;

    // Unpack the observed status word.
    always_comb begin
        st     = status_word[DATA_W +: 3];
        rd     = status_word[DATA_W-1:0];
        pend_f = status_word[DATA_W+3];
        sync_f = status_word[DATA_W+4];
        init_f = status_word[DATA_W+5];
    end

    a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        rmt_req |=> !rmt_req);

    a_r3_req_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd2) |=> (st == 3'd4));

    a_r2_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd4) |=> ($stable(rmt_addr) && $stable(rmt_wdata) && $stable(rmt_we)));

    a_r4_read_park: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd4 && rmt_ack && !rmt_we) |=> (st == 3'd6 && rd == $past(rmt_rdata)));

    a_r5_park_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd6 && !(clr_wr && clr_bit)) |=> (st == 3'd6 && $stable(rd)));

    a_r5_park_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd6 && clr_wr && clr_bit) |=> (st == 3'd0));

    a_r6_write_done: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd4 && rmt_ack && rmt_we) |=> (st == 3'd0));

    a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && st != 3'd0) |=> (cmd_err && !rmt_req));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    a_r8_req_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rmt_req |-> (!sync_f && pend_f));

    a_r9_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_f |=> init_f);

endmodule

bind register_access_channel rac_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .STS_W  (STS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .clr_wr      (clr_wr),
    .clr_bit     (clr_bit),
    .rmt_req     (rmt_req),
    .rmt_we      (rmt_we),
    .rmt_addr    (rmt_addr),
    .rmt_wdata   (rmt_wdata),
    .rmt_ack     (rmt_ack),
    .rmt_rdata   (rmt_rdata),
    .status_word (status_word),
    .cmd_err     (cmd_err)
);

// File: tb/tb_register_access_channel.sv
// Scoreboard bench: driver tasks queue expected remote requests and read
// results; a remote model and a status monitor pop and compare them.
module tb_register_access_channel;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_wr;
    logic [31:0] cmd_word;
    logic        clr_wr, clr_bit, init_wr, init_bit;
    logic [31:0] status_word;
    logic        cmd_err, rmt_req, rmt_we;
    logic [14:0] rmt_addr;
    logic [15:0] rmt_wdata;
    logic        rmt_ack;
    logic [15:0] rmt_rdata;

    int checks = 0;
    int errors = 0;
    int req_seen = 0;
    int req_sent = 0;

    logic [31:0] exp_req[$];
    logic [15:0] exp_rd[$];
    logic [15:0] remote_mem[16];
    logic [15:0] shadow[16];

    always #5 clk = ~clk;

    register_access_channel dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .clr_wr(clr_wr), .clr_bit(clr_bit), .init_wr(init_wr), .init_bit(init_bit),
        .status_word(status_word), .cmd_err(cmd_err), .rmt_req(rmt_req),
        .rmt_we(rmt_we), .rmt_addr(rmt_addr), .rmt_wdata(rmt_wdata),
        .rmt_ack(rmt_ack), .rmt_rdata(rmt_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic [2:0] st_f();
        return status_word[18:16];
    endfunction

    task automatic poke_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_wr = 1'b0;
        cmd_word = '0;
    endtask

    // Accepted command: queue the expected remote request and read result.
    task automatic issue(input logic w, input logic [14:0] a, input logic [15:0] d);
        exp_req.push_back({w, a, d});
        req_sent++;
        if (w) shadow[a[3:0]] = d;
        else   exp_rd.push_back(shadow[a[3:0]]);
        poke_cmd({w, a, d});
    endtask

    task automatic wait_state(input logic [2:0] s, input string tag);
        for (int i = 0; i < 50; i++) begin
            if (st_f() == s) return;
            @(negedge clk);
        end
        chk(tag, {29'd0, st_f()}, {29'd0, s});
    endtask

    task automatic pulse_clr(input logic b);
        @(negedge clk);
        clr_wr = 1'b1; clr_bit = b;
        @(negedge clk);
        clr_wr = 1'b0; clr_bit = 1'b0;
    endtask

    task automatic pulse_init(input logic b);
        @(negedge clk);
        init_wr = 1'b1; init_bit = b;
        @(negedge clk);
        init_wr = 1'b0; init_bit = 1'b0;
    endtask

    // Remote model: fixed-latency acknowledge, checks request fields (R2).
    initial begin
        logic [31:0] e;
        rmt_ack = 1'b0;
        rmt_rdata = '0;
        forever begin
            @(negedge clk);
            if (rmt_req) begin
                req_seen++;
                if (exp_req.size() == 0) begin
                    chk("R2 unexpected remote request", {rmt_we, rmt_addr, rmt_wdata}, 32'h0);
                end else begin
                    e = exp_req.pop_front();
                    chk("R2 remote request fields", {rmt_we, rmt_addr, rmt_wdata}, e);
                end
                if (rmt_we) remote_mem[rmt_addr[3:0]] = rmt_wdata;
                repeat (LAT - 1) @(negedge clk);
                rmt_ack = 1'b1;
                rmt_rdata = rmt_we ? 16'h0 : remote_mem[rmt_addr[3:0]];
                @(negedge clk);
                rmt_ack = 1'b0;
                rmt_rdata = '0;
            end
        end
    end

    // Monitor: on entry to the parked state compare read data (R4).
    initial begin
        logic [2:0] prev = 3'd0;
        forever begin
            @(negedge clk);
            if (rst_n && st_f() == 3'd6 && prev != 3'd6) begin
                if (exp_rd.size() == 0)
                    chk("R4 unexpected read result", {16'd0, status_word[15:0]}, 32'h0);
                else
                    chk("R4 read data", {16'd0, status_word[15:0]}, {16'd0, exp_rd.pop_front()});
            end
            prev = rst_n ? st_f() : 3'd0;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            remote_mem[i] = 16'hC300 + 16'(i) * 16'h0111;
            shadow[i]     = 16'hC300 + 16'(i) * 16'h0111;
        end
        rst_n = 1'b0;
        cmd_wr = 1'b0; cmd_word = '0;
        clr_wr = 1'b0; clr_bit = 1'b0;
        init_wr = 1'b0; init_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 reset status", status_word, 32'h0010_0000);
        chk("R1 reset err", {31'd0, cmd_err}, 32'd0);
        chk("R1 reset req", {31'd0, rmt_req}, 32'd0);

        // Write: state sequence and flags (R3, R8, R6)
        issue(1'b1, 15'h0003, 16'hBEEF);
        chk("R3 request state", {29'd0, st_f()}, 32'd2);
        chk("R8 pending in request", {31'd0, status_word[19]}, 32'd1);
        chk("R8 sync low in request", {31'd0, status_word[20]}, 32'd0);
        chk("R3 req high", {31'd0, rmt_req}, 32'd1);
        @(negedge clk);
        chk("R3 wait state", {29'd0, st_f()}, 32'd4);
        chk("R3 req single cycle", {31'd0, rmt_req}, 32'd0);
        chk("R8 sync low while waiting", {30'd0, status_word[20:19]}, 32'd0);
        wait_state(3'd0, "R6 write to idle");
        chk("R6 write idle without clear", {29'd0, st_f()}, 32'd0);
        chk("R8 sync back high", {31'd0, status_word[20]}, 32'd1);

        // Read back parks (R4, R5)
        issue(1'b0, 15'h0003, 16'h0000);
        wait_state(3'd6, "R4 read parks");
        repeat (5) @(negedge clk);
        chk("R5 park holds state", {29'd0, st_f()}, 32'd6);
        chk("R5 park holds data", {16'd0, status_word[15:0]}, 32'h0000_BEEF);
        pulse_clr(1'b0);
        chk("R5 clear of 0 ignored", {29'd0, st_f()}, 32'd6);

        // Busy command while parked (R7)
        chk("R7 err clear before busy command", {31'd0, cmd_err}, 32'd0);
        poke_cmd({1'b1, 15'h0005, 16'h1234});
        chk("R7 no request when busy", {31'd0, rmt_req}, 32'd0);
        chk("R7 parked state untouched", {29'd0, st_f()}, 32'd6);
        chk("R7 err set", {31'd0, cmd_err}, 32'd1);

        pulse_clr(1'b1);
        chk("R5 clear releases", {29'd0, st_f()}, 32'd0);
        pulse_clr(1'b1);
        chk("R5 idle clear no effect", status_word, 32'h0010_BEEF);

        // Busy command while waiting for data (R7)
        issue(1'b0, 15'h7FFF, 16'h0000);
        @(negedge clk);
        poke_cmd({1'b1, 15'h0001, 16'hDEAD});
        wait_state(3'd6, "R7 read survives busy command");
        pulse_clr(1'b1);
        chk("R7 err still set", {31'd0, cmd_err}, 32'd1);

        // Boundary address and data (R2, R4)
        issue(1'b1, 15'h7FFF, 16'hFFFF);
        wait_state(3'd0, "R6 boundary write");
        issue(1'b0, 15'h7FFF, 16'h0000);
        wait_state(3'd6, "R4 boundary read");
        pulse_clr(1'b1);
        issue(1'b0, 15'h0000, 16'h0000);
        wait_state(3'd6, "R4 address zero read");
        pulse_clr(1'b1);
        repeat (2) @(negedge clk);
        chk("R7 only accepted commands reached remote", req_seen, req_sent);

        // Init-done (R9)
        pulse_init(1'b0);
        chk("R9 init write 0 no effect", {31'd0, status_word[21]}, 32'd0);
        pulse_init(1'b1);
        chk("R9 init set", {31'd0, status_word[21]}, 32'd1);
        pulse_init(1'b0);
        chk("R9 init stays", {31'd0, status_word[21]}, 32'd1);
        chk("R10 upper bits zero", {22'd0, status_word[31:22]}, 32'd0);

        // Mid-run reset (R1, R9)
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after reset", status_word, 32'h0010_0000);
        chk("R9 init cleared by reset", {31'd0, status_word[21]}, 32'd0);
        chk("R1 err cleared by reset", {31'd0, cmd_err}, 32'd0);

        chk("R4 all reads observed", exp_rd.size(), 32'd0);
        chk("R2 all requests observed", exp_req.size(), 32'd0);
        finish_run();
    end

endmodule